// File: doc/BRIEF.md
# Split-Bus Command/Address Issuer

This block sits in a requesting node on a bus whose address half and data half are separate. Each transaction takes one command/address cycle on the address half. The data phase that follows is handled elsewhere. Requests enter a small in-order queue through a valid/ready handshake. Each request carries a command, an address and a 4-bit memory bank number. Before the head request may compete for the bus, the block looks up that bank in a one-bit-per-bank busy vector. It only raises its request line when the bank can accept work and the global arbitration-suppress input is low.

Arbitration between nodes is not part of this block. It appears only as a grant input. Once the block sees the grant while it is requesting, it drives the command, address and bank together for exactly one cycle. It then expects the command acknowledge in precisely the second cycle after that one. An acknowledge in any other cycle is ignored. If the acknowledge is missing, the block pulses an error flag, waits a programmable backoff and issues the same request again. A request leaves the queue only when it has been acknowledged, so requests go out strictly in the order they arrived.

Top module: `addr_issuer`

## Requirements
- R1: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high; `in_ready` is low exactly when DEPTH requests are held and not yet acknowledged.
- R2: Requests are issued strictly in arrival order, and each issue cycle carries the stored command, address and bank of the queue head on `ca_cmd`, `ca_addr`, `ca_bank`.
- R3: `arb_req` does not rise while bit `bank_busy[b]` is 1, where b is the bank number of the queue head (bit index equals bank number). A busy head also holds back every request queued behind it.
- R4: `arb_req` is high in the cycle before every command/address cycle. `ca_valid` is high for exactly one cycle per attempt: the cycle after one in which `arb_req` and `arb_grant` are both high.
- R5: While `arb_suppress` is high, `arb_req` does not rise and `ca_valid` is low in the following cycle. A request already raised is withdrawn in the cycle after suppress is seen.
- R6: `cmd_ack` is sampled only in the cycle exactly two after the command/address cycle. An acknowledge in that cycle retires the request. An acknowledge one cycle early has no effect.
- R7: A missing acknowledge makes `ack_err` high for one cycle, three cycles after the command/address cycle. The same request is then issued again with its command/address cycle exactly `backoff_cfg`+6 cycles after the failed one, provided grant is high and the bank is free.
- R8: While `arb_grant` stays low, `arb_req` stays high and nothing is issued.
- R9: Synchronous reset clears the queue and leaves `arb_req`, `ca_valid` and `ack_err` low and `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Queue has room |
| in_cmd | input | CMD_W | Command of the offered request |
| in_addr | input | ADDR_W | Address of the offered request |
| in_bank | input | BANK_W | Memory bank number of the offered request |
| bank_busy | input | 2**BANK_W | One busy bit per bank, indexed by bank number |
| arb_suppress | input | 1 | Global flow control: stop arbitrating |
| backoff_cfg | input | BO_W | Idle cycles added before a retry |
| arb_req | output | 1 | Bus request line |
| arb_grant | input | 1 | Grant from the external arbiter |
| ca_valid | output | 1 | Command/address cycle on the bus |
| ca_cmd | output | CMD_W | Driven command |
| ca_addr | output | ADDR_W | Driven address |
| ca_bank | output | BANK_W | Driven bank number |
| cmd_ack | input | 1 | Command acknowledge from the target |
| ack_err | output | 1 | One-cycle pulse on a missing acknowledge |

## Verification
A queue pointer that slips shows at the next command/address cycle as a reordered or corrupted command, address or bank. A controller that samples the acknowledge in the wrong cycle shows within three cycles of an issue. It either raises a spurious `ack_err` or fails to retry after an early acknowledge. A broken bank or suppress gate shows as an issue during a window in which the ports must stay quiet. A miscounted backoff shifts the retry cycle by a measurable amount.

// File: rtl/issuer_pkg.sv
package issuer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CA,
    ST_GAP,
    ST_CHK,
    ST_BACK
  } iss_state_t;
endpackage

// File: rtl/issue_queue.sv
module issue_queue #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_word,
  input  logic             pop,
  output logic             full,
  output logic             nonempty,
  output logic [WIDTH-1:0] head_word
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  // write port: plain synchronous array write, no reset on contents
  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full      = (count == FULL_CNT);
  assign nonempty  = (count != '0);
  assign head_word = store[rd_ptr];

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    full && !pop |=> full);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    !nonempty && !push |=> !nonempty);
endmodule

// File: rtl/bank_gate.sv
module bank_gate #(
  parameter int BANK_W = 4
) (
  input  logic [BANK_W-1:0]      bank,
  input  logic [(1<<BANK_W)-1:0] busy_vec,
  output logic                   bank_blocked
);
  localparam int NBANK = 1 << BANK_W;

  logic [NBANK-1:0] hit;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign hit[g] = busy_vec[g] && (bank == BANK_W'(g));
  end

  assign bank_blocked = |hit;
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import issuer_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int BO_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_valid,
  input  logic [WIDTH-1:0] head_word,
  input  logic             head_blocked,
  input  logic             arb_suppress,
  input  logic [BO_W-1:0]  backoff_cfg,
  input  logic             arb_grant,
  input  logic             cmd_ack,
  output logic             arb_req,
  output logic             ca_valid,
  output logic [WIDTH-1:0] ca_word,
  output logic             ack_err,
  output logic             retire
);
  iss_state_t       state;
  logic [BO_W-1:0]  bo_cnt;

  // the acknowledge is only looked at in the second cycle after the C/A cycle
  assign retire = (state == ST_CHK) && cmd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      arb_req  <= 1'b0;
      ca_valid <= 1'b0;
      ca_word  <= '0;
      ack_err  <= 1'b0;
      bo_cnt   <= '0;
    end else begin
      ca_valid <= 1'b0;
      ack_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (head_valid && !head_blocked && !arb_suppress) begin
            arb_req <= 1'b1;
            state   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (arb_suppress || head_blocked) begin
            arb_req <= 1'b0;
            state   <= ST_IDLE;
          end else if (arb_grant) begin
            arb_req  <= 1'b0;
            ca_valid <= 1'b1;
            ca_word  <= head_word;
            state    <= ST_CA;
          end
        end
        ST_CA:  state <= ST_GAP;
        ST_GAP: state <= ST_CHK;
        ST_CHK: begin
          if (cmd_ack) begin
            state <= ST_IDLE;
          end else begin
            ack_err <= 1'b1;
            bo_cnt  <= backoff_cfg;
            state   <= ST_BACK;
          end
        end
        ST_BACK: begin
          if (bo_cnt == '0) state <= ST_IDLE;
          else              bo_cnt <= bo_cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_before_ca_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ca_valid) |-> $past(arb_req));
  assert_single_ca_R4: assert property (@(posedge clk) disable iff (rst)
    ca_valid |=> !ca_valid);
  assert_bank_free_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_req) |-> $past(!head_blocked));
  assert_suppress_req_R5: assert property (@(posedge clk) disable iff (rst)
    arb_suppress && !arb_req |=> !arb_req);
  assert_suppress_ca_R5: assert property (@(posedge clk) disable iff (rst)
    arb_suppress |=> !ca_valid);
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ack_err |=> !ack_err);
  assert_no_grant_R8: assert property (@(posedge clk) disable iff (rst)
    arb_req && !arb_grant && !arb_suppress && !head_blocked |=> arb_req && !ca_valid);
endmodule

// File: rtl/addr_issuer.sv
module addr_issuer #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4,
  parameter int DEPTH  = 4,
  parameter int BO_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CMD_W-1:0]       in_cmd,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [BANK_W-1:0]      in_bank,
  input  logic [(1<<BANK_W)-1:0] bank_busy,
  input  logic                   arb_suppress,
  input  logic [BO_W-1:0]        backoff_cfg,
  output logic                   arb_req,
  input  logic                   arb_grant,
  output logic                   ca_valid,
  output logic [CMD_W-1:0]       ca_cmd,
  output logic [ADDR_W-1:0]      ca_addr,
  output logic [BANK_W-1:0]      ca_bank,
  input  logic                   cmd_ack,
  output logic                   ack_err
);
  localparam int WORD_W = CMD_W + ADDR_W + BANK_W;

  logic              q_full, q_nonempty, retire, head_blocked;
  logic [WORD_W-1:0] head_word, ca_word;

  assign in_ready = !q_full;

  issue_queue #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (in_valid && !q_full),
    .push_word ({in_cmd, in_addr, in_bank}),
    .pop       (retire),
    .full      (q_full),
    .nonempty  (q_nonempty),
    .head_word (head_word)
  );

  bank_gate #(.BANK_W(BANK_W)) u_gate (
    .bank         (head_word[BANK_W-1:0]),
    .busy_vec     (bank_busy),
    .bank_blocked (head_blocked)
  );

  issue_ctrl #(.WIDTH(WORD_W), .BO_W(BO_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .head_valid   (q_nonempty),
    .head_word    (head_word),
    .head_blocked (head_blocked),
    .arb_suppress (arb_suppress),
    .backoff_cfg  (backoff_cfg),
    .arb_grant    (arb_grant),
    .cmd_ack      (cmd_ack),
    .arb_req      (arb_req),
    .ca_valid     (ca_valid),
    .ca_word      (ca_word),
    .ack_err      (ack_err),
    .retire       (retire)
  );

  assign {ca_cmd, ca_addr, ca_bank} = ca_word;

  assert_retire_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
    retire |-> q_nonempty);
endmodule

// File: tb/addr_issuer_bench.sv
module addr_issuer_bench;
  localparam int CMD_W = 4, ADDR_W = 16, BANK_W = 4, DEPTH = 4, BO_W = 8;
  localparam int WORD_W = CMD_W + ADDR_W + BANK_W;
  localparam int BACKOFF = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [CMD_W-1:0] in_cmd = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [BANK_W-1:0] in_bank = '0;
  logic [15:0] bank_busy = '0;
  logic arb_suppress = 1'b0, arb_req, arb_grant = 1'b0;
  logic [BO_W-1:0] backoff_cfg = BO_W'(BACKOFF);
  logic ca_valid, cmd_ack = 1'b0, ack_err;
  logic [CMD_W-1:0] ca_cmd;
  logic [ADDR_W-1:0] ca_addr;
  logic [BANK_W-1:0] ca_bank;

  always #5 clk = ~clk;

  addr_issuer #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
                .DEPTH(DEPTH), .BO_W(BO_W)) u_addr_issuer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_addr(in_addr), .in_bank(in_bank),
    .bank_busy(bank_busy), .arb_suppress(arb_suppress),
    .backoff_cfg(backoff_cfg), .arb_req(arb_req), .arb_grant(arb_grant),
    .ca_valid(ca_valid), .ca_cmd(ca_cmd), .ca_addr(ca_addr),
    .ca_bank(ca_bank), .cmd_ack(cmd_ack), .ack_err(ack_err)
  );

  int checks = 0, fails = 0;
  int cyc = 0, ca_count = 0, err_count = 0, exp_errs = 0;
  int last_ca = -100;
  int last_mode = 0;
  logic prev_req = 1'b0;
  logic [WORD_W-1:0] exp_q[$];
  int exp_mode[$];
  int ack_plan[$];

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // driver: queue expectations (mode 0 normal ack, 1 none, 2 early), then offer request
  task automatic push_req(input logic [CMD_W-1:0] c, input logic [ADDR_W-1:0] a,
                          input logic [BANK_W-1:0] b, input int mode);
    exp_q.push_back({c, a, b}); exp_mode.push_back(mode); ack_plan.push_back(mode);
    if (mode != 0) begin
      exp_errs++;
      exp_q.push_back({c, a, b}); exp_mode.push_back(0); ack_plan.push_back(0);
    end
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_cmd = c; in_addr = a; in_bank = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // monitor: compares every command/address cycle with the scoreboard head
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ca_valid) begin
        ca_count++;
        // R4: request line high in the cycle before the C/A cycle
        check(prev_req == 1'b1, "R4 req before CA", longint'(prev_req), 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected issue", longint'({ca_cmd, ca_addr, ca_bank}), 0);
        end else begin
          logic [WORD_W-1:0] e;
          int m;
          e = exp_q.pop_front();
          m = exp_mode.pop_front();
          check({ca_cmd, ca_addr, ca_bank} == e, "R2 issue order/fields",
                longint'({ca_cmd, ca_addr, ca_bank}), longint'(e));
          if (last_mode != 0)  // R7: retry spacing after a missing acknowledge
            check(cyc - last_ca == BACKOFF + 6, "R7 retry spacing",
                  cyc - last_ca, BACKOFF + 6);
          last_mode = m;
        end
        last_ca = cyc;
      end
      if (ack_err) begin
        err_count++;
        check(cyc == last_ca + 3 && last_mode != 0, "R7 err timing",
              cyc - last_ca, 3);
      end
    end
    prev_req = arb_req;
  end

  // responder: acknowledges according to the plan for each attempt
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && ca_valid) begin
        int m;
        m = (ack_plan.size() != 0) ? ack_plan.pop_front() : 0;
        if (m == 0) begin
          @(negedge clk); @(negedge clk);
          cmd_ack = 1'b1;
          @(negedge clk);
          cmd_ack = 1'b0;
        end else if (m == 2) begin  // R6: acknowledge one cycle early
          @(negedge clk);
          cmd_ack = 1'b1;
          @(negedge clk);
          cmd_ack = 1'b0;
        end
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(arb_req == 1'b0, "R9 arb_req", longint'(arb_req), 0);
    check(ca_valid == 1'b0, "R9 ca_valid", longint'(ca_valid), 0);
    check(ack_err == 1'b0, "R9 ack_err", longint'(ack_err), 0);
    check(in_ready == 1'b1, "R9 in_ready", longint'(in_ready), 1);
    rst = 1'b0;
    arb_grant = 1'b1;
    @(negedge clk);

    // R2: burst of requests, distinct banks
    push_req(4'h1, 16'h1000, 4'd0, 0);
    push_req(4'h2, 16'h2345, 4'd7, 0);
    push_req(4'h3, 16'hBEEF, 4'd15, 0);
    drain();

    // R3: head bank busy blocks it and the one behind it
    bank_busy = 16'h0020;
    base = ca_count;
    push_req(4'h4, 16'h0505, 4'd5, 0);
    push_req(4'h5, 16'h0202, 4'd2, 0);
    repeat (15) @(negedge clk);
    check(ca_count == base, "R3 busy bank issued", ca_count - base, 0);
    check(arb_req == 1'b0, "R3 req while busy", longint'(arb_req), 0);
    bank_busy = 16'h0000;
    drain();

    // R5: suppress holds off arbitration
    arb_suppress = 1'b1;
    base = ca_count;
    push_req(4'h6, 16'h6666, 4'd3, 0);
    repeat (10) @(negedge clk);
    check(ca_count == base, "R5 issue under suppress", ca_count - base, 0);
    check(arb_req == 1'b0, "R5 req under suppress", longint'(arb_req), 0);
    arb_suppress = 1'b0;
    drain();

    // R8: no grant keeps request high; R5: suppress withdraws it
    arb_grant = 1'b0;
    base = ca_count;
    push_req(4'h7, 16'h7777, 4'd9, 0);
    repeat (10) @(negedge clk);
    check(arb_req == 1'b1, "R8 req held", longint'(arb_req), 1);
    check(ca_count == base, "R8 issue without grant", ca_count - base, 0);
    arb_suppress = 1'b1;
    @(negedge clk);
    check(arb_req == 1'b0, "R5 withdraw", longint'(arb_req), 0);
    arb_suppress = 1'b0;
    arb_grant = 1'b1;
    drain();

    // R7: missing acknowledge, then R6: early acknowledge
    push_req(4'h8, 16'h8888, 4'd1, 1);
    push_req(4'h9, 16'h9999, 4'd4, 0);
    drain();
    push_req(4'hA, 16'hAAAA, 4'd6, 2);
    drain();
    check(err_count == exp_errs, "R6/R7 error count", err_count, exp_errs);

    // R1: queue fills while grant is withheld
    arb_grant = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      push_req(CMD_W'(i + 11), ADDR_W'(16'hC000 + i), BANK_W'(i + 8), 0);
    check(in_ready == 1'b0, "R1 in_ready when full", longint'(in_ready), 0);
    arb_grant = 1'b1;
    drain();
    check(in_ready == 1'b1, "R1 in_ready after drain", longint'(in_ready), 1);
    check(exp_q.size() == 0, "R2 all issued", exp_q.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule